// File: doc/BRIEF.md
# Cache Way Lockdown and Victim Selector

This block holds the per-way lock state of a four-way set-associative cache, with one register for the data cache and one for the instruction cache. Privileged software reads and writes these registers through a coprocessor-style access port. The port checks the privilege level and the security world of each access, and also a non-secure access enable bit. Only then does it let an access through. A refused access returns an undefined-instruction flag and leaves both registers untouched.

When the cache needs a line fill, the block picks the victim way for that cache. It never picks a locked way. It starts from either a pseudo-random position or a per-cache round-robin pointer, as a policy input selects, and moves upward with wrap-around to the first unlocked way. Ways that are not built are treated as permanently locked. A cache whose ways are all locked still fills into way 0.

Both registers are common to the secure and non-secure worlds. The tag arrays, the data arrays and the fill datapath live elsewhere.

Top module: `cache_way_lockdown`

## Requirements
- R1: The low `WAYS` bits of a lock register map bit n to way n. A 1 bars allocation into that way and a 0 permits it. A permitted write updates these bits at the clock edge on which it is presented. A permitted read returns them in `acc_rdata[WAYS-1:0]` one cycle after the request, with `acc_done` high in that cycle.
- R2: Reset is synchronous and active high. It clears every implemented lock bit, resets both round-robin pointers to way 0, and drives `acc_done`, `acc_undef`, `acc_rdata` and `fill_valid` low.
- R3: A way at or above `IMPL_WAYS` always reads as locked (1), and writes to its bit have no effect.
- R4: A permitted read returns ones in every `acc_rdata` bit above the lock field. The matching write-data bits are ignored.
- R5: The operation code `acc_op` selects the register: 0 selects the data-cache register and 1 selects the instruction-cache register. Any other code raises `acc_undef` and changes nothing.
- R6: A user-mode access (`acc_priv`=0) always raises `acc_undef`. A privileged non-secure access raises it unless `ns_lock_access` is 1. A privileged secure access is always permitted. A refused access changes no register and returns `acc_rdata` = 0. `acc_undef` appears one cycle after the request.
- R7: A fill request gives `fill_valid` = 1 one cycle later, with a `fill_way` that is unlocked in the chosen cache's register as it stood in the request cycle. `fill_instr`=1 chooses the instruction cache and 0 chooses the data cache.
- R8: With `fill_policy_rr`=0, the search starts at the low two bits of a 16-bit LFSR, sampled in the request cycle. The LFSR loads 16'hACE1 during reset. It then steps on every clock: it shifts right, and XORs in 16'hB400 when the bit shifted out is 1. The search moves upward, wrapping at the top, to the first unlocked way.
- R9: With `fill_policy_rr`=1, the search starts at that cache's own round-robin pointer and moves upward with wrap-around to the first unlocked way. The pointer then becomes the chosen way plus one, modulo `WAYS`. Random-policy fills leave both pointers unchanged.
- R10: If every way of the chosen cache is locked, the victim search treats way 0 as unlocked, so the fill goes to way 0.
- R11: The registers are not banked by world. A value written from one world is what a permitted access from the other world reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Register access request |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_op | input | 3 | Register select (0 data, 1 instruction) |
| acc_priv | input | 1 | Access made from a privileged mode |
| acc_secure | input | 1 | Access made from the secure world |
| ns_lock_access | input | 1 | Lets privileged non-secure accesses through |
| acc_wdata | input | DATA_W | Write data |
| acc_done | output | 1 | Access finished, one cycle after request |
| acc_undef | output | 1 | Access refused (undefined) |
| acc_rdata | output | DATA_W | Read data |
| fill_req | input | 1 | Line fill needs a victim way |
| fill_instr | input | 1 | 1 = instruction cache, 0 = data cache |
| fill_policy_rr | input | 1 | 1 = round-robin, 0 = pseudo-random |
| fill_valid | output | 1 | Victim way valid, one cycle after request |
| fill_way | output | $clog2(WAYS) | Chosen victim way |

## Verification
Every result has a latency of one clock. Access completion, the refusal flag and read data all appear in the cycle after the request. The victim way follows the fill request by one cycle, and a lock write first affects a fill requested in the cycle after the write. The bench model computes each result at the request edge from the inputs and its own state. The outputs are then compared at the following falling edge, every cycle, for a four-way instance and a three-way instance together. When a write and a fill arrive in the same cycle, the model uses the old lock value for the fill, which matches the one-edge latency.

// File: rtl/wl_pkg.sv
package wl_pkg;
  typedef enum logic [2:0] {
    OP_DATA_LOCK  = 3'd0,
    OP_INSTR_LOCK = 3'd1
  } lock_op_e;

  localparam int NUM_CACHES = 2;
  localparam int CACHE_DATA = 0;
  localparam int CACHE_INSTR = 1;
endpackage

// File: rtl/wl_access.sv
module wl_access
  import wl_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       valid_i,
  input  logic [2:0] op_i,
  input  logic       priv_i,
  input  logic       secure_i,
  input  logic       ns_en_i,
  output logic       grant_o,
  output logic       deny_o,
  output logic       sel_instr_o
);
  logic op_known;
  logic world_ok;

  always_comb begin
    op_known    = (op_i == OP_DATA_LOCK) || (op_i == OP_INSTR_LOCK);
    world_ok    = secure_i || ns_en_i;
    grant_o     = valid_i && priv_i && world_ok && op_known;
    deny_o      = valid_i && !grant_o;
    sel_instr_o = (op_i == OP_INSTR_LOCK);
  end

  assert_secure_priv_ok_R6: assert property (@(posedge clk) disable iff (rst)
    valid_i && priv_i && secure_i && !op_i[2] && !op_i[1] |-> grant_o);
endmodule

// File: rtl/wl_lock_reg.sv
module wl_lock_reg #(
  parameter int WAYS      = 4,
  parameter int IMPL_WAYS = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we_i,
  input  logic [WAYS-1:0] wdata_i,
  output logic [WAYS-1:0] lock_o
);
  localparam logic [WAYS-1:0] IMPL_MASK = WAYS'((1 << IMPL_WAYS) - 1);

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    if (g < IMPL_WAYS) begin : g_impl
      logic bit_q;
      always_ff @(posedge clk) begin
        if (rst)       bit_q <= 1'b0;
        else if (we_i) bit_q <= wdata_i[g];
      end
      assign lock_o[g] = bit_q;
    end else begin : g_absent
      assign lock_o[g] = 1'b1;
    end
  end

  assert_write_lands_R1: assert property (@(posedge clk) disable iff (rst)
    we_i |=> (lock_o & IMPL_MASK) == ($past(wdata_i) & IMPL_MASK));
endmodule

// File: rtl/wl_victim.sv
module wl_victim #(
  parameter int                 WAYS   = 4,
  parameter int                 LFSR_W = 16,
  parameter logic [LFSR_W-1:0]  SEED   = 16'hACE1,
  parameter logic [LFSR_W-1:0]  TAPS   = 16'hB400
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     fill_req_i,
  input  logic                     fill_instr_i,
  input  logic                     policy_rr_i,
  input  logic [WAYS-1:0]          dlock_i,
  input  logic [WAYS-1:0]          ilock_i,
  output logic                     fill_valid_o,
  output logic [$clog2(WAYS)-1:0]  fill_way_o
);
  localparam int IDX_W = $clog2(WAYS);
  localparam logic [WAYS-1:0] ALL_BUT_0 = {{(WAYS-1){1'b1}}, 1'b0};

  logic [LFSR_W-1:0] lfsr_q;
  logic [IDX_W-1:0]  rr_ptr_q [2];
  logic [WAYS-1:0]   raw_lock, eff_lock;
  logic [IDX_W-1:0]  start_way, pick_way;

  function automatic logic [IDX_W-1:0] first_free(input logic [WAYS-1:0] lk,
                                                  input logic [IDX_W-1:0] start);
    logic [IDX_W-1:0] r;
    logic found;
    r = start;
    found = 1'b0;
    for (int k = 0; k < WAYS; k++) begin
      logic [IDX_W-1:0] idx;
      idx = start + IDX_W'(k);
      if (!found && !lk[idx]) begin
        r = idx;
        found = 1'b1;
      end
    end
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) lfsr_q <= SEED;
    else     lfsr_q <= lfsr_q[0] ? ((lfsr_q >> 1) ^ TAPS) : (lfsr_q >> 1);
  end

  always_comb begin
    raw_lock  = fill_instr_i ? ilock_i : dlock_i;
    eff_lock  = (&raw_lock) ? ALL_BUT_0 : raw_lock;
    start_way = policy_rr_i ? rr_ptr_q[fill_instr_i] : lfsr_q[IDX_W-1:0];
    pick_way  = first_free(eff_lock, start_way);
  end

  for (genvar c = 0; c < 2; c++) begin : g_ptr
    always_ff @(posedge clk) begin
      if (rst)
        rr_ptr_q[c] <= '0;
      else if (fill_req_i && policy_rr_i && (fill_instr_i == c[0]))
        rr_ptr_q[c] <= pick_way + IDX_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fill_valid_o <= 1'b0;
      fill_way_o   <= '0;
    end else begin
      fill_valid_o <= fill_req_i;
      if (fill_req_i) fill_way_o <= pick_way;
    end
  end

  assert_fill_latency_R7: assert property (@(posedge clk) disable iff (rst)
    fill_req_i |=> fill_valid_o);
  assert_victim_unlocked_R7: assert property (@(posedge clk) disable iff (rst)
    fill_valid_o |-> ($past(eff_lock) & (WAYS'(1) << fill_way_o)) == '0);
  assert_full_lock_way0_R10: assert property (@(posedge clk) disable iff (rst)
    fill_req_i && (&raw_lock) |=> fill_way_o == '0);
endmodule

// File: rtl/cache_way_lockdown.sv
module cache_way_lockdown #(
  parameter int DATA_W    = 32,
  parameter int WAYS      = 4,
  parameter int IMPL_WAYS = 4,
  parameter int LFSR_W    = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    acc_valid,
  input  logic                    acc_write,
  input  logic [2:0]              acc_op,
  input  logic                    acc_priv,
  input  logic                    acc_secure,
  input  logic                    ns_lock_access,
  input  logic [DATA_W-1:0]       acc_wdata,
  output logic                    acc_done,
  output logic                    acc_undef,
  output logic [DATA_W-1:0]       acc_rdata,
  input  logic                    fill_req,
  input  logic                    fill_instr,
  input  logic                    fill_policy_rr,
  output logic                    fill_valid,
  output logic [$clog2(WAYS)-1:0] fill_way
);
  localparam int PAD_W = DATA_W - WAYS;

  logic grant, deny, sel_instr;
  logic we_d, we_i;
  logic [WAYS-1:0] dlock, ilock, rd_lock;

  wl_access u_access (
    .clk(clk), .rst(rst), .valid_i(acc_valid), .op_i(acc_op),
    .priv_i(acc_priv), .secure_i(acc_secure), .ns_en_i(ns_lock_access),
    .grant_o(grant), .deny_o(deny), .sel_instr_o(sel_instr)
  );

  assign we_d = grant && acc_write && !sel_instr;
  assign we_i = grant && acc_write && sel_instr;

  wl_lock_reg #(.WAYS(WAYS), .IMPL_WAYS(IMPL_WAYS)) u_dlock (
    .clk(clk), .rst(rst), .we_i(we_d), .wdata_i(acc_wdata[WAYS-1:0]), .lock_o(dlock)
  );
  wl_lock_reg #(.WAYS(WAYS), .IMPL_WAYS(IMPL_WAYS)) u_ilock (
    .clk(clk), .rst(rst), .we_i(we_i), .wdata_i(acc_wdata[WAYS-1:0]), .lock_o(ilock)
  );

  assign rd_lock = sel_instr ? ilock : dlock;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_done  <= 1'b0;
      acc_undef <= 1'b0;
      acc_rdata <= '0;
    end else begin
      acc_done  <= acc_valid;
      acc_undef <= deny;
      acc_rdata <= (grant && !acc_write) ? {{PAD_W{1'b1}}, rd_lock} : '0;
    end
  end

  wl_victim #(.WAYS(WAYS), .LFSR_W(LFSR_W)) u_victim (
    .clk(clk), .rst(rst), .fill_req_i(fill_req), .fill_instr_i(fill_instr),
    .policy_rr_i(fill_policy_rr), .dlock_i(dlock), .ilock_i(ilock),
    .fill_valid_o(fill_valid), .fill_way_o(fill_way)
  );

  assert_user_undef_R6: assert property (@(posedge clk) disable iff (rst)
    acc_valid && !acc_priv |=> acc_undef && acc_rdata == '0);
  assert_denied_write_R6: assert property (@(posedge clk) disable iff (rst)
    acc_valid && acc_write && !acc_priv |=> $stable(dlock) && $stable(ilock));
  assert_upper_ones_R4: assert property (@(posedge clk) disable iff (rst)
    acc_valid && !acc_write && acc_priv && acc_secure && acc_op == 3'd0
      |=> &acc_rdata[DATA_W-1:WAYS]);
endmodule

// File: tb/tb_cache_way_lockdown.sv
module tb_cache_way_lockdown;
  logic clk = 1'b0;
  logic rst;
  logic acc_valid, acc_write, acc_priv, acc_secure, ns_lock_access;
  logic [2:0] acc_op;
  logic [31:0] acc_wdata;
  logic fill_req, fill_instr, fill_policy_rr;

  logic        done   [2];
  logic        undef  [2];
  logic [31:0] rdata  [2];
  logic        fvalid [2];
  logic [1:0]  fway   [2];

  always #5 clk = ~clk;

  cache_way_lockdown dut (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write), .acc_op(acc_op),
    .acc_priv(acc_priv), .acc_secure(acc_secure), .ns_lock_access(ns_lock_access),
    .acc_wdata(acc_wdata), .acc_done(done[0]), .acc_undef(undef[0]), .acc_rdata(rdata[0]),
    .fill_req(fill_req), .fill_instr(fill_instr), .fill_policy_rr(fill_policy_rr),
    .fill_valid(fvalid[0]), .fill_way(fway[0])
  );

  cache_way_lockdown #(.IMPL_WAYS(3)) dut3 (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write), .acc_op(acc_op),
    .acc_priv(acc_priv), .acc_secure(acc_secure), .ns_lock_access(ns_lock_access),
    .acc_wdata(acc_wdata), .acc_done(done[1]), .acc_undef(undef[1]), .acc_rdata(rdata[1]),
    .fill_req(fill_req), .fill_instr(fill_instr), .fill_policy_rr(fill_policy_rr),
    .fill_valid(fvalid[1]), .fill_way(fway[1])
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference model state
  logic [3:0]  m_lock [2][2];
  logic [1:0]  m_ptr  [2][2];
  logic [15:0] m_lfsr;
  logic        e_done [2], e_undef [2], e_fv [2];
  logic [31:0] e_rdata [2];
  logic [1:0]  e_fw [2];
  string       e_wtag, e_utag;
  bit          started = 0;

  function automatic logic [3:0] absent_mask(int inst);
    return (inst == 1) ? 4'b1000 : 4'b0000;
  endfunction

  task automatic check(string tag, string what, int inst, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s inst%0d actual=%h expected=%h at %0t", tag, what, inst, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_lfsr = 16'hACE1;
      for (int i = 0; i < 2; i++) begin
        for (int c = 0; c < 2; c++) begin
          m_lock[i][c] = absent_mask(i);
          m_ptr[i][c]  = 2'd0;
        end
        e_done[i] = 0; e_undef[i] = 0; e_fv[i] = 0; e_rdata[i] = 0;
      end
    end else begin
      for (int i = 0; i < 2; i++) begin
        // victim selection uses the lock value from before any same-cycle write
        e_fv[i] = fill_req;
        if (fill_req) begin
          logic [3:0] lk;
          int st, w, c;
          c  = fill_instr ? 1 : 0;
          lk = m_lock[i][c];
          if (lk == 4'hF) begin lk = 4'hE; e_wtag = "R10"; end
          else e_wtag = fill_policy_rr ? "R9" : "R8";
          st = fill_policy_rr ? int'(m_ptr[i][c]) : int'(m_lfsr % 16'd4);
          w = st;
          for (int k = 3; k >= 0; k--) if (!lk[(st + k) % 4]) w = (st + k) % 4;
          e_fw[i] = w[1:0];
          if (fill_policy_rr) m_ptr[i][c] = 2'((w + 1) % 4);
        end
        e_done[i] = acc_valid;
        begin
          bit ok;
          ok = acc_valid && acc_priv && (acc_secure || ns_lock_access) && (acc_op < 3'd2);
          e_undef[i] = acc_valid && !ok;
          e_utag = (acc_op >= 3'd2) ? "R5" : "R6";
          e_rdata[i] = (ok && !acc_write) ? {28'hFFFFFFF, m_lock[i][acc_op[0]]} : 32'h0;
          if (ok && acc_write) m_lock[i][acc_op[0]] = acc_wdata[3:0] | absent_mask(i);
        end
      end
      m_lfsr = m_lfsr[0] ? ((m_lfsr >> 1) ^ 16'hB400) : (m_lfsr >> 1);
      started = 1;
    end
  end

  always @(negedge clk) begin
    if (started && !rst) begin
      for (int i = 0; i < 2; i++) begin
        check("R1", "acc_done", i, {31'b0, done[i]}, {31'b0, e_done[i]});
        check(e_utag, "acc_undef", i, {31'b0, undef[i]}, {31'b0, e_undef[i]});
        if (e_done[i]) check("R1 R3 R4 R11", "acc_rdata", i, rdata[i], e_rdata[i]);
        check("R7", "fill_valid", i, {31'b0, fvalid[i]}, {31'b0, e_fv[i]});
        if (e_fv[i]) check(e_wtag, "fill_way", i, {30'b0, fway[i]}, {30'b0, e_fw[i]});
      end
    end
  end

  task automatic idle();
    @(negedge clk);
    acc_valid = 0; acc_write = 0; acc_op = 0; acc_priv = 1; acc_secure = 1;
    acc_wdata = 0; fill_req = 0; fill_instr = 0; fill_policy_rr = 0;
  endtask

  task automatic access(bit wr, logic [2:0] op, bit priv, bit sec, logic [31:0] wd);
    @(negedge clk);
    acc_valid = 1; acc_write = wr; acc_op = op; acc_priv = priv; acc_secure = sec;
    acc_wdata = wd; fill_req = 0;
  endtask

  task automatic fill(bit instr, bit rr);
    @(negedge clk);
    acc_valid = 0; fill_req = 1; fill_instr = instr; fill_policy_rr = rr;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired (R1..R11 incomplete)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    rst = 1; ns_lock_access = 0;
    acc_valid = 0; acc_write = 0; acc_op = 0; acc_priv = 1; acc_secure = 1;
    acc_wdata = 0; fill_req = 0; fill_instr = 0; fill_policy_rr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R2: outputs after reset
    for (int i = 0; i < 2; i++) begin
      check("R2", "reset done/undef/fill_valid", i, {29'b0, done[i], undef[i], fvalid[i]}, 32'h0);
      check("R2", "reset rdata", i, rdata[i], 32'h0);
    end
    rst = 0;
    // R2/R4/R3: reset values read back
    access(0, 3'd0, 1, 1, 0);
    access(0, 3'd1, 1, 1, 0);
    // R1: write and read back
    access(1, 3'd0, 1, 1, 32'h0000_0005);
    access(1, 3'd1, 1, 1, 32'h0000_000A);
    access(0, 3'd0, 1, 1, 0);
    access(0, 3'd1, 1, 1, 0);
    // R6: user and non-secure refusals, then read
    access(1, 3'd0, 0, 1, 32'hF);
    access(1, 3'd0, 1, 0, 32'hF);
    access(0, 3'd0, 1, 0, 0);
    // R5: unknown op
    access(1, 3'd3, 1, 1, 32'hF);
    access(0, 3'd7, 1, 1, 0);
    // R11: non-secure enabled, writes then secure read
    ns_lock_access = 1;
    access(1, 3'd0, 1, 0, 32'h0000_0009);
    access(0, 3'd0, 1, 1, 0);
    access(0, 3'd0, 1, 0, 0);
    // R9: round robin with locks 1001 data and 1010 instr
    for (int n = 0; n < 6; n++) fill(0, 1);
    for (int n = 0; n < 6; n++) fill(1, 1);
    // R8: random
    for (int n = 0; n < 10; n++) fill(n[0], 0);
    // R10: all locked
    access(1, 3'd0, 1, 1, 32'hF);
    fill(0, 0);
    fill(0, 1);
    access(1, 3'd1, 1, 1, 32'h7);
    fill(1, 1);
    fill(1, 0);
    idle();
    // mixed pseudo-random stimulus, write and fill may coincide
    seed = 32'h1234_5678;
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      seed = seed * 1103515245 + 12345;
      acc_valid      = seed[16];
      acc_write      = seed[17];
      acc_op         = seed[20:18] & (seed[21] ? 3'b111 : 3'b001);
      acc_priv       = seed[22] | seed[23];
      acc_secure     = seed[24];
      ns_lock_access = seed[25];
      acc_wdata      = {seed[15:0], seed[31:16]};
      fill_req       = seed[26] | seed[27];
      fill_instr     = seed[28];
      fill_policy_rr = seed[29];
    end
    idle();
    idle();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule